// File: doc/BRIEF.md
# Latched Parallel-to-Serial Shift Register

This block holds a parallel word in a storage latch and feeds it into a shift register. The last stage of the shift register drives a single serial output. A parallel word is captured on a rising edge of a capture strobe. The word moves into the shift register while the mode input selects load. With the mode input at shift, a shift strobe moves the word out one bit per edge, and a serial input bit enters at the far end. A typical host captures a snapshot of parallel status and then clocks it out over a serial link. Because the latch is separate, a new snapshot can be taken while the previous one is still shifting out.

All control inputs are asynchronous to the system clock. They are resynchronised and acted on at their rising edges. An active-low output enable can take the serial output off the link without touching any stored bit. When disabled, a drive-enable flag drops and the registered data output holds its last value. A wrapper-level pin carries a real high-impedance value.

Top module: `lpsr_top`

## Requirements
- R1: A rising edge of `cap_strobe` loads `par_in` into the storage latch, whatever the mode. `par_in[0]` is stage A and `par_in[WIDTH-1]` is stage H.
- R2: While `mode_shift` is 1, each rising edge of `shift_strobe` moves every stage one place toward H and loads `ser_in` into stage A. The bit leaving stage H is dropped.
- R3: While `mode_shift` is 0, the shift register follows the storage latch on every clock. Shift strobe edges and `ser_in` have no effect.
- R4: While `mode_shift` is 0, a capture edge places the new `par_in` word into the latch and the shift register in the same clock.
- R5: While `mode_shift` is 1, a capture edge updates only the latch. The shift register keeps its contents until `mode_shift` returns to 0, and then it takes the new latch word.
- R6: If both strobes rise together while `mode_shift` is 1, the latch loads `par_in` and the register shifts in the same clock.
- R7: While `oe_n` is 0, `drive_en` is 1, and `ser_out` and `ser_pin` show stage H with one register of delay.
- R8: While `oe_n` is 1, `drive_en` is 0, `ser_out` holds its last value and `ser_pin` is high impedance. Latch and register contents are unaffected.
- R9: Strobes and mode pass through a SYNC_STAGES-deep synchroniser. Each strobe rising edge acts exactly once, however long the strobe stays high.
- R10: A synchronous active-high `rst` clears the latch, the shift register, the synchroniser and edge history, `ser_out` and `drive_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | WIDTH | Parallel word, bit 0 = stage A |
| ser_in | input | 1 | Serial data entering stage A |
| mode_shift | input | 1 | 1 = shift mode, 0 = load from latch |
| cap_strobe | input | 1 | Latch capture strobe, rising-edge active |
| shift_strobe | input | 1 | Shift strobe, rising-edge active |
| oe_n | input | 1 | Active-low output enable |
| ser_out | output | 1 | Registered stage-H value |
| drive_en | output | 1 | 1 when the serial output is driven |
| ser_pin | output | 1 | Serial pin, 'z' when disabled |

## Verification
The shift path is tried with three patterns. A word loaded through the latch checks stage ordering, because H must emerge first. A word built purely from serial bits checks the entry point at stage A. A single set bit reaching H at the last step checks the combined capture-and-shift case. A capture made in shift mode is followed by a switch back to load mode; this separates "latch only" from "latch and register". A strobe held high for many clocks separates edge action from level action. Toggling the enable around a capture shows that the enable gates only the pin, and a full readout afterwards confirms the stored bits.

// File: rtl/lpsr_pkg.sv
package lpsr_pkg;
   // Index map of the control bundle passed through the synchroniser
   localparam int CTRL_CAP   = 0;
   localparam int CTRL_SHIFT = 1;
   localparam int CTRL_MODE  = 2;
   localparam int CTRL_N     = 3;
   // Number of strobes that are edge detected (the low CTRL indices)
   localparam int STROBE_N   = 2;
endpackage

// File: rtl/lpsr_sync.sv
module lpsr_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   logic [N-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= '0;
               else     chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= '0;
               else     chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lpsr_edge.sv
module lpsr_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] level,
   output logic [N-1:0] rise
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= '0;
      else     prev_q <= level;
   end

   assign rise = level & ~prev_q;

   // R9: an edge pulse never lasts two clocks
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
      (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/lpsr_core.sv
module lpsr_core #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   input  logic             mode_shift,
   input  logic             cap_rise,
   input  logic             shift_rise,
   output logic [WIDTH-1:0] stage_q
);
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] shifted;
   logic [WIDTH-1:0] load_word;

   // Storage latch: captures regardless of mode
   always_ff @(posedge clk) begin
      if (rst)           latch_q <= '0;
      else if (cap_rise) latch_q <= par_in;
   end

   // Shift next-state: stage A takes the serial bit, stage i takes i-1
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_shift
         if (i == 0) begin : g_head
            assign shifted[0] = ser_in;
         end else begin : g_body
            assign shifted[i] = stage_q[i-1];
         end
      end
   endgenerate

   // In load mode a same-cycle capture bypasses the latch
   assign load_word = cap_rise ? par_in : latch_q;

   always_ff @(posedge clk) begin
      if (rst)              stage_q <= '0;
      else if (!mode_shift) stage_q <= load_word;
      else if (shift_rise)  stage_q <= shifted;
   end

   // R1: capture lands in the latch
   a_r1_capture: assert property (@(posedge clk) disable iff (rst)
      cap_rise |=> latch_q == $past(par_in));
   // R2 / R6: shift moves toward H with serial input at A
   a_r2_shift: assert property (@(posedge clk) disable iff (rst)
      (mode_shift && shift_rise) |=>
         stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)});
   // R3: load mode follows the latch
   a_r3_follow: assert property (@(posedge clk) disable iff (rst)
      (!mode_shift && !cap_rise) |=> stage_q == $past(latch_q));
   // R4: combined load
   a_r4_combined: assert property (@(posedge clk) disable iff (rst)
      (!mode_shift && cap_rise) |=>
         (stage_q == $past(par_in)) && (latch_q == $past(par_in)));
   // R5: shift mode without a shift edge keeps the register
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (mode_shift && !shift_rise) |=> $stable(stage_q));
endmodule

// File: rtl/lpsr_out.sv
module lpsr_out (
   input  logic clk,
   input  logic rst,
   input  logic stage_h,
   input  logic oe_n,
   output logic ser_out,
   output logic drive_en
);
   always_ff @(posedge clk) begin
      if (rst) begin
         ser_out  <= 1'b0;
         drive_en <= 1'b0;
      end else begin
         drive_en <= ~oe_n;
         if (!oe_n) ser_out <= stage_h;
      end
   end

   // R7: enabled output tracks stage H one clock later
   a_r7_track: assert property (@(posedge clk) disable iff (rst)
      !oe_n |=> (ser_out == $past(stage_h)) && drive_en);
   // R8: disabled output holds and is not driven
   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      oe_n |=> !drive_en && $stable(ser_out));
endmodule

// File: rtl/lpsr_top.sv
module lpsr_top #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   input  logic             mode_shift,
   input  logic             cap_strobe,
   input  logic             shift_strobe,
   input  logic             oe_n,
   output logic             ser_out,
   output logic             drive_en,
   output logic             ser_pin
);
   import lpsr_pkg::*;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("lpsr_top: WIDTH must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lpsr_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CTRL_N-1:0]   ctrl_raw;
   logic [CTRL_N-1:0]   ctrl_sync;
   logic [STROBE_N-1:0] strobe_rise;
   logic [WIDTH-1:0]    stage_q;

   always_comb begin
      ctrl_raw             = '0;
      ctrl_raw[CTRL_CAP]   = cap_strobe;
      ctrl_raw[CTRL_SHIFT] = shift_strobe;
      ctrl_raw[CTRL_MODE]  = mode_shift;
   end

   lpsr_sync #(.N(CTRL_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (ctrl_raw),
      .q   (ctrl_sync)
   );

   lpsr_edge #(.N(STROBE_N)) u_edge (
      .clk   (clk),
      .rst   (rst),
      .level (ctrl_sync[STROBE_N-1:0]),
      .rise  (strobe_rise)
   );

   lpsr_core #(.WIDTH(WIDTH)) u_core (
      .clk        (clk),
      .rst        (rst),
      .par_in     (par_in),
      .ser_in     (ser_in),
      .mode_shift (ctrl_sync[CTRL_MODE]),
      .cap_rise   (strobe_rise[CTRL_CAP]),
      .shift_rise (strobe_rise[CTRL_SHIFT]),
      .stage_q    (stage_q)
   );

   lpsr_out u_out (
      .clk      (clk),
      .rst      (rst),
      .stage_h  (stage_q[WIDTH-1]),
      .oe_n     (oe_n),
      .ser_out  (ser_out),
      .drive_en (drive_en)
   );

   assign ser_pin = drive_en ? ser_out : 1'bz;

   // R10: the cycle after reset the outputs are cleared
   a_r10_reset: assert property (@(posedge clk)
      rst |=> !ser_out && !drive_en && (stage_q == '0));
endmodule

// File: tb/lpsr_top_tb_top.sv
module lpsr_top_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] par_in = '0;
   logic         ser_in = 1'b0;
   logic         mode_shift = 1'b0;
   logic         cap_strobe = 1'b0;
   logic         shift_strobe = 1'b0;
   logic         oe_n = 1'b0;
   logic         ser_out, drive_en, ser_pin;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   lpsr_top #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst(rst), .par_in(par_in), .ser_in(ser_in),
      .mode_shift(mode_shift), .cap_strobe(cap_strobe),
      .shift_strobe(shift_strobe), .oe_n(oe_n),
      .ser_out(ser_out), .drive_en(drive_en), .ser_pin(ser_pin)
   );

   typedef struct {
      logic  out;
      logic  en;
      string tag;
   } exp_t;

   exp_t sb_q[$];

   // reference model
   logic [W-1:0] m_latch = '0;
   logic [W-1:0] m_sr    = '0;
   logic         m_mode  = 1'b0;
   logic         m_hold  = 1'b0;

   // monitor: pops expected items and compares against the ports
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         logic pin_ok;
         e = sb_q.pop_front();
         checks++;
         pin_ok = e.en ? (ser_pin === e.out) : (ser_pin === 1'bz);
         if (ser_out !== e.out || drive_en !== e.en || !pin_ok) begin
            errors++;
            $display("FAIL %s: ser_out=%b drive_en=%b pin=%b expected out=%b en=%b",
                     e.tag, ser_out, drive_en, ser_pin, e.out, e.en);
         end
      end
   end

   task automatic push(input logic o, input logic en, input string tag);
      exp_t e;
      e.out = o; e.en = en; e.tag = tag;
      sb_q.push_back(e);
      wait (sb_q.size() == 0);
      @(negedge clk);
   endtask

   task automatic expect_model(input string tag);
      if (!oe_n) begin
         m_hold = m_sr[W-1];
         push(m_hold, 1'b1, tag);
      end else begin
         push(m_hold, 1'b0, tag);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_mode(input logic m);
      mode_shift = m;
      m_mode = m;
      if (!m) m_sr = m_latch;
      settle(6);
   endtask

   task automatic capture(input logic [W-1:0] d);
      par_in = d;
      cap_strobe = 1'b1;
      settle(4);
      cap_strobe = 1'b0;
      settle(4);
      m_latch = d;
      if (!m_mode) m_sr = d;
   endtask

   task automatic shift_one(input logic b, input int hold);
      ser_in = b;
      shift_strobe = 1'b1;
      settle(hold);
      shift_strobe = 1'b0;
      settle(4);
      if (m_mode) m_sr = {m_sr[W-2:0], b};
   endtask

   task automatic both(input logic [W-1:0] d, input logic b);
      par_in = d;
      ser_in = b;
      cap_strobe = 1'b1;
      shift_strobe = 1'b1;
      settle(4);
      cap_strobe = 1'b0;
      shift_strobe = 1'b0;
      settle(4);
      m_latch = d;
      if (m_mode) m_sr = {m_sr[W-2:0], b};
      else        m_sr = d;
   endtask

   // mode must be shift: checks H first down to A, one shift between checks
   task automatic readout(input logic [W-1:0] exp_word, input string tag);
      for (int i = W - 1; i >= 0; i--) begin
         if (m_sr[W-1] !== exp_word[i]) begin
            $display("bench model mismatch in %s", tag);
         end
         expect_model(tag);
         shift_one(1'b0, 4);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      settle(3);
      m_latch = '0; m_sr = '0; m_hold = 1'b0;
      push(1'b0, 1'b0, "R10 outputs cleared in reset");
      rst = 1'b0;
      settle(4);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      settle(1);
      do_reset();
      expect_model("R7 enabled output after reset");

      // R4 combined load, then R2 readout H first
      set_mode(1'b0);
      capture(8'hA5);
      expect_model("R4 combined latch and register load");
      set_mode(1'b1);
      readout(8'hA5, "R2 parallel word shifts out H first");

      // R2 serial fill via stage A
      for (int i = W - 1; i >= 0; i--) shift_one(8'h3C >> i, 4);
      readout(8'h3C, "R2 serial word entered at stage A");

      // R3 shift ignored in load mode
      set_mode(1'b0);
      expect_model("R3 register follows latch");
      shift_one(1'b1, 4);
      expect_model("R3 shift edge ignored in load mode");
      set_mode(1'b1);
      readout(8'hA5, "R3 contents unchanged by ignored shift");

      // R5 capture in shift mode touches latch only
      capture(8'hC3);
      expect_model("R5 register unchanged after capture in shift mode");
      set_mode(1'b0);
      expect_model("R5 register takes new latch on mode low");
      set_mode(1'b1);
      readout(8'hC3, "R5 transferred word");

      // R6 simultaneous strobes in shift mode
      both(8'h96, 1'b1);
      readout(8'h01, "R6 shift during simultaneous capture");
      set_mode(1'b0);
      set_mode(1'b1);
      readout(8'h96, "R6 latch loaded during simultaneous shift");

      // R9 long strobe acts once
      set_mode(1'b0);
      capture(8'h40);
      set_mode(1'b1);
      shift_one(1'b0, 20);
      expect_model("R9 held strobe shifts exactly once");
      readout(8'h80, "R9 single shift word");

      // R8 output enable
      set_mode(1'b0);
      capture(8'hE7);
      expect_model("R7 stage H driven");
      oe_n = 1'b1;
      settle(3);
      expect_model("R8 disabled output holds and floats");
      capture(8'h18);
      expect_model("R8 disabled output holds across capture");
      oe_n = 1'b0;
      settle(3);
      expect_model("R8 re-enabled output shows new stage H");
      set_mode(1'b1);
      oe_n = 1'b1;
      settle(3);
      oe_n = 1'b0;
      settle(3);
      readout(8'h18, "R8 stored word intact after enable toggles");

      // R10 mid-run reset
      set_mode(1'b0);
      capture(8'hFF);
      expect_model("R4 all-ones load");
      mode_shift = 1'b1; m_mode = 1'b1;
      do_reset();
      settle(4);
      readout(8'h00, "R10 register cleared by reset");
      set_mode(1'b0);
      set_mode(1'b1);
      readout(8'h00, "R10 latch cleared by reset");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule